// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of one of two intermediate-frequency inputs, here called the AM input and the FM input. It counts the rising edges of the selected input during a gate window of fixed length. A small control register selects the input, the count mode and the gate length, and it can be written either as a whole byte or one bit at a time. A start strobe opens the gate. The gate length is measured in ticks of a 1 kHz reference enable, which is divided down from the system clock. When the gate closes, the edge count is copied into a result register and a done flag rises.

Each raw input passes through a two-flop synchroniser before edge detection. The counter saturates at its maximum value instead of wrapping. An input that the current selection does not use is reported as released, so the surrounding pin logic can hand it back to general-purpose port use. A stop request puts the block in low-power stop: it clears the control register and cancels any measurement. A halt request freezes the register at its current value.

Top module: `ifc_gated_counter`

## Requirements
- R1: After reset, and on the clock after `stop_req` is high, the control register reads 0x00.
- R2: A byte write (`reg_wr`) loads `reg_wdata[3:0]` into the control register. Bits 7:4 of `reg_rdata` always read 0.
- R3: A single-bit write (`reg_bit_wr`) sets bit `reg_bit_idx` of the register to `reg_bit_val` and leaves the other bits unchanged. An index of 4 to 7 has no effect. A byte write in the same cycle wins.
- R4: While `halt` is high, both kinds of write are ignored and the register keeps its value.
- R5: The source field is register bits 3:2. Code 01 counts the AM input in AM mode, 10 counts the FM input in FM mode, and 11 counts the FM input in AM mode. `am_count_mode` is high for codes 01 and 11 only.
- R6: `am_released` is high unless the source code is 01. `fm_released` is high unless the source code is 10 or 11. Code 00 releases both inputs.
- R7: The gate field is register bits 1:0. Codes 00, 01 and 10 keep `busy` high for 1, 4 and 8 reference ticks, where one tick is TICK_DIV clock cycles.
- R8: A start is ignored while the source code is 00, while the gate code is 11, and while a measurement is already running.
- R9: Only rising edges of the selected input are counted, after the two-flop synchroniser. The unselected input has no effect. The source and gate settings are captured when the start is accepted.
- R10: The count saturates at 2^RES_W-1 and never wraps.
- R11: When the gate closes, `result` takes the count and `done` rises. `done` stays high, and `result` stays unchanged, until the next accepted start, which clears `done`.
- R12: A stop request cancels a running measurement: `busy` and `done` are low on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | Enter low-power stop: clears the register and cancels a measurement |
| halt | input | 1 | Halt: freezes the control register |
| reg_wr | input | 1 | Byte write strobe |
| reg_wdata | input | BUS_W (8) | Byte write data |
| reg_bit_wr | input | 1 | Single-bit write strobe |
| reg_bit_idx | input | IDX_W (3) | Bit index for a single-bit write |
| reg_bit_val | input | 1 | Value for a single-bit write |
| reg_rdata | output | BUS_W (8) | Control register readback |
| start | input | 1 | Start measurement strobe |
| am_in | input | 1 | AM intermediate-frequency input |
| fm_in | input | 1 | FM intermediate-frequency input |
| result | output | RES_W (16) | Latched, saturating edge count |
| busy | output | 1 | Gate open |
| done | output | 1 | Measurement finished |
| am_released | output | 1 | AM input free for port use |
| fm_released | output | 1 | FM input free for port use |
| am_count_mode | output | 1 | Counting in AM mode |

## Verification
Measurements are run with square waves of several half-periods on the selected input. This checks that edges are counted only on the rising transition and only within the window, offset by the synchroniser delay. In each run the other input toggles at full rate: a nonzero count from the cross code 11 with the FM input held low would show that the wrong input is wired in. A toggle every cycle over the longest gate, with a narrow result width, separates saturation from wrap-around. A second start while busy, and a stop partway through a gate, show whether the window is restarted or cancelled.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

  // source field codes (register bits 3:2)
  localparam logic [1:0] SRC_OFF   = 2'b00;
  localparam logic [1:0] SRC_AM_AM = 2'b01;
  localparam logic [1:0] SRC_FM_FM = 2'b10;
  localparam logic [1:0] SRC_FM_AM = 2'b11;

  // gate field codes (register bits 1:0)
  localparam logic [1:0] GATE_1    = 2'b00;
  localparam logic [1:0] GATE_4    = 2'b01;
  localparam logic [1:0] GATE_8    = 2'b10;
  localparam logic [1:0] GATE_OPEN = 2'b11;

  // number of reference ticks in the window; 0 for the unused code
  function automatic logic [3:0] gate_ticks(input logic [1:0] code);
    case (code)
      GATE_1:  return 4'd1;
      GATE_4:  return 4'd4;
      GATE_8:  return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic start_legal(input logic [1:0] src, input logic [1:0] gate);
    return (src != SRC_OFF) && (gate != GATE_OPEN);
  endfunction

  function automatic logic uses_fm_pin(input logic [1:0] src);
    return (src == SRC_FM_FM) || (src == SRC_FM_AM);
  endfunction

  function automatic logic uses_am_pin(input logic [1:0] src);
    return src == SRC_AM_AM;
  endfunction

  function automatic logic am_mode(input logic [1:0] src);
    return (src == SRC_AM_AM) || (src == SRC_FM_AM);
  endfunction

endpackage

// File: rtl/ifc_mode_reg.sv
module ifc_mode_reg #(
  parameter int unsigned FIELD_W = 4,
  parameter int unsigned BUS_W   = 8,
  localparam int unsigned IDX_W  = $clog2(BUS_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stop_req,
  input  logic               halt,
  input  logic               byte_wr,
  input  logic [BUS_W-1:0]   byte_data,
  input  logic               bit_wr,
  input  logic [IDX_W-1:0]   bit_idx,
  input  logic               bit_val,
  output logic [FIELD_W-1:0] field_q,
  output logic [BUS_W-1:0]   rdata
);

  logic [FIELD_W-1:0] field_nxt;
  logic               hi_bits_unused;

  // upper byte bits are not stored
  assign hi_bits_unused = |byte_data[BUS_W-1:FIELD_W];

  always_comb begin
    field_nxt = field_q;
    if (byte_wr) begin
      field_nxt = byte_data[FIELD_W-1:0];
    end else begin
      for (int i = 0; i < FIELD_W; i++) begin
        if (bit_wr && bit_idx == IDX_W'(i)) field_nxt[i] = bit_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        field_q <= '0;
    else if (stop_req) field_q <= '0;
    else if (!halt)    field_q <= field_nxt;
  end

  assign rdata = {{(BUS_W-FIELD_W){1'b0}}, field_q};

endmodule

// File: rtl/ifc_ref_tick.sv
module ifc_ref_tick #(
  parameter int unsigned TICK_DIV = 125000,
  localparam int unsigned DIV_W   = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic tick
);

  logic [DIV_W-1:0] div_q;

  assign tick = en && (div_q == DIV_W'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (clr) div_q <= '0;
    else if (en)  div_q <= tick ? '0 : div_q + DIV_W'(1);
  end

endmodule

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
  parameter int unsigned CH     = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] raw,
  output logic [CH-1:0] rise
);

  for (genvar ch = 0; ch < CH; ch++) begin : g_ch
    // STAGES synchroniser flops plus one history flop
    logic [STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STAGES-1:0], raw[ch]};
    end

    assign rise[ch] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  end

endmodule

// File: rtl/ifc_gated_counter.sv
module ifc_gated_counter
  import ifc_pkg::*;
#(
  parameter int unsigned TICK_DIV = 125000,
  parameter int unsigned RES_W    = 16,
  parameter int unsigned BUS_W    = 8,
  localparam int unsigned IDX_W   = $clog2(BUS_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic             halt,
  input  logic             reg_wr,
  input  logic [BUS_W-1:0] reg_wdata,
  input  logic             reg_bit_wr,
  input  logic [IDX_W-1:0] reg_bit_idx,
  input  logic             reg_bit_val,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             start,
  input  logic             am_in,
  input  logic             fm_in,
  output logic [RES_W-1:0] result,
  output logic             busy,
  output logic             done,
  output logic             am_released,
  output logic             fm_released,
  output logic             am_count_mode
);

  localparam int unsigned FIELD_W = 4;
  localparam int unsigned CH_AM   = 0;
  localparam int unsigned CH_FM   = 1;

  function automatic logic [RES_W-1:0] sat_inc(input logic [RES_W-1:0] v);
    return (&v) ? v : v + RES_W'(1);
  endfunction

  logic [FIELD_W-1:0] field_q;
  logic [1:0]         src_code;
  logic [1:0]         gate_code;

  // named internal events
  logic               start_ok;
  logic               ref_tick;
  logic               gate_close;
  logic               rise_sel;
  logic [1:0]         rise;

  logic               busy_q, done_q, fm_sel_q;
  logic [3:0]         tgt_q, tick_cnt_q;
  logic [RES_W-1:0]   cnt_q, cnt_nxt, result_q;

  ifc_mode_reg #(.FIELD_W(FIELD_W), .BUS_W(BUS_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_req  (stop_req),
    .halt      (halt),
    .byte_wr   (reg_wr),
    .byte_data (reg_wdata),
    .bit_wr    (reg_bit_wr),
    .bit_idx   (reg_bit_idx),
    .bit_val   (reg_bit_val),
    .field_q   (field_q),
    .rdata     (reg_rdata)
  );

  assign src_code  = field_q[3:2];
  assign gate_code = field_q[1:0];

  assign start_ok = start && !busy_q && !stop_req && start_legal(src_code, gate_code);

  ifc_ref_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_ok),
    .en    (busy_q),
    .tick  (ref_tick)
  );

  ifc_edge_sync #(.CH(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   ({fm_in, am_in}),
    .rise  (rise)
  );

  assign rise_sel   = fm_sel_q ? rise[CH_FM] : rise[CH_AM];
  assign cnt_nxt    = rise_sel ? sat_inc(cnt_q) : cnt_q;
  assign gate_close = busy_q && ref_tick && (tick_cnt_q == tgt_q - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      fm_sel_q   <= 1'b0;
      tgt_q      <= '0;
      tick_cnt_q <= '0;
      cnt_q      <= '0;
      result_q   <= '0;
    end else if (stop_req) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_ok) begin
      busy_q     <= 1'b1;
      done_q     <= 1'b0;
      cnt_q      <= '0;
      tick_cnt_q <= '0;
      tgt_q      <= gate_ticks(gate_code);
      fm_sel_q   <= uses_fm_pin(src_code);
    end else if (busy_q) begin
      cnt_q <= cnt_nxt;
      if (ref_tick) tick_cnt_q <= tick_cnt_q + 4'd1;
      if (gate_close) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        result_q <= cnt_nxt;
      end
    end
  end

  assign busy          = busy_q;
  assign done          = done_q;
  assign result        = result_q;
  assign am_released   = !uses_am_pin(src_code);
  assign fm_released   = !uses_fm_pin(src_code);
  assign am_count_mode = am_mode(src_code);

endmodule

// File: rtl/ifc_checker.sv
module ifc_checker #(
  parameter int unsigned RES_W = 16,
  parameter int unsigned BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req,
  input logic             halt,
  input logic             start,
  input logic [BUS_W-1:0] reg_rdata,
  input logic             busy,
  input logic             done,
  input logic [RES_W-1:0] result,
  input logic [RES_W-1:0] cnt_q
);

  AST_STOP_CLEARS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (reg_rdata == '0)); // R1

  AST_HALT_HOLDS_REG: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !stop_req) |=> $stable(reg_rdata)); // R4

  AST_START_NEEDS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && $past(reg_rdata[3:2]) != 2'b00 && $past(reg_rdata[1:0]) != 2'b11)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(cnt_q) == {RES_W{1'b1}}) |-> (cnt_q == {RES_W{1'b1}})); // R10

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R11

  AST_CLOSE_RAISES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(stop_req)) |-> done); // R11

  AST_RESULT_ONLY_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> $fell(busy)); // R11

  AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (!busy && !done)); // R12

endmodule

bind ifc_gated_counter ifc_checker #(.RES_W(RES_W), .BUS_W(BUS_W)) u_ifc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .stop_req  (stop_req),
  .halt      (halt),
  .start     (start),
  .reg_rdata (reg_rdata),
  .busy      (busy),
  .done      (done),
  .result    (result),
  .cnt_q     (cnt_q)
);

// File: tb/test_ifc_gated_counter.sv
`timescale 1ns/1ps
module test_ifc_gated_counter;

  localparam int TB_DIV = 20;
  localparam int TB_RES = 6;
  localparam int MAXV   = (1 << TB_RES) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_req = 1'b0, halt = 1'b0;
  logic       reg_wr = 1'b0, reg_bit_wr = 1'b0, reg_bit_val = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [2:0] reg_bit_idx = '0;
  logic [7:0] reg_rdata;
  logic       start = 1'b0, am_in = 1'b0, fm_in = 1'b0;
  logic [TB_RES-1:0] result;
  logic       busy, done, am_released, fm_released, am_count_mode;

  always #4 clk = ~clk;

  ifc_gated_counter #(.TICK_DIV(TB_DIV), .RES_W(TB_RES)) i_ifc_gated_counter (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .halt(halt),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_bit_wr(reg_bit_wr),
    .reg_bit_idx(reg_bit_idx), .reg_bit_val(reg_bit_val), .reg_rdata(reg_rdata),
    .start(start), .am_in(am_in), .fm_in(fm_in), .result(result),
    .busy(busy), .done(done), .am_released(am_released),
    .fm_released(fm_released), .am_count_mode(am_count_mode)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_reg, m_busy, m_done, m_result, m_cnt, m_elapsed, m_len, m_fm;
  bit am_h[$], fm_h[$];

  task automatic model_step();
    int src, g, rs;
    if (!rst_n) begin
      m_reg = 0; m_busy = 0; m_done = 0; m_result = 0; m_cnt = 0;
      m_elapsed = 0; m_len = 0; m_fm = 0;
      am_h = '{0, 0, 0, 0}; fm_h = '{0, 0, 0, 0};
      return;
    end
    am_h.push_back(am_in); fm_h.push_back(fm_in);
    while (am_h.size() > 4) void'(am_h.pop_front());
    while (fm_h.size() > 4) void'(fm_h.pop_front());
    // an input level reaches the edge detector two clocks after capture
    rs = m_fm ? (fm_h[1] && !fm_h[0]) : (am_h[1] && !am_h[0]);
    src = (m_reg >> 2) & 3;
    g = m_reg & 3;
    if (stop_req) begin
      m_busy = 0; m_done = 0;
    end else if (m_busy) begin
      m_elapsed++;
      if (rs && m_cnt < MAXV) m_cnt++;
      if (m_elapsed == m_len) begin
        m_busy = 0; m_done = 1; m_result = m_cnt;
      end
    end else if (start && src != 0 && g != 3) begin
      m_busy = 1; m_done = 0; m_cnt = 0; m_elapsed = 0;
      m_len = (g == 0 ? 1 : (g == 1 ? 4 : 8)) * TB_DIV;
      m_fm = (src >= 2);
    end
    if (stop_req) m_reg = 0;
    else if (!halt) begin
      if (reg_wr) m_reg = reg_wdata & 15;
      else if (reg_bit_wr && reg_bit_idx < 4)
        m_reg = reg_bit_val ? (m_reg | (1 << reg_bit_idx)) : (m_reg & ~(1 << reg_bit_idx));
    end
  endtask

  always @(posedge clk) begin
    int src;
    model_step();
    #1;
    src = (m_reg >> 2) & 3;
    check("R2 reg_rdata", int'(reg_rdata), m_reg);
    check("R7 busy", int'(busy), m_busy);
    check("R11 done", int'(done), m_done);
    check("R9 result", int'(result), m_result);
    check("R6 am_released", int'(am_released), int'(src != 1));
    check("R6 fm_released", int'(fm_released), int'(src < 2));
    check("R5 am_count_mode", int'(am_count_mode), int'(src == 1 || src == 3));
  end

  // ---------------- input pattern generator ----------------
  int am_half = 0, fm_half = 0, am_ph = 0, fm_ph = 0;

  initial forever begin
    @(negedge clk);
    if (am_half > 0) begin
      am_ph++;
      if (am_ph >= am_half) begin am_ph = 0; am_in = ~am_in; end
    end else am_in = 1'b0;
    if (fm_half > 0) begin
      fm_ph++;
      if (fm_ph >= fm_half) begin fm_ph = 0; fm_in = ~fm_in; end
    end else fm_in = 1'b0;
  end

  // ---------------- stimulus tasks ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic wr_bit(input logic [2:0] idx, input logic val);
    @(negedge clk); reg_bit_wr = 1'b1; reg_bit_idx = idx; reg_bit_val = val;
    @(negedge clk); reg_bit_wr = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
  endtask

  // start, then count the cycles busy stays high; optional second start
  task automatic run_gate(input int exp_len, input int restart_at, input string tag);
    int n;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (busy && n < 5000) begin
      n++;
      start = (n == restart_at);
      @(negedge clk);
    end
    start = 1'b0;
    check(tag, n, exp_len);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL R7 watchdog act=timeout exp=finished");
    finish_run();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    check("R1 rdata after reset", int'(reg_rdata), 0);
    check("R1 busy after reset", int'(busy), 0);

    wr_byte(8'hF6);
    check("R2 upper bits dropped", int'(reg_rdata), 6);
    wr_bit(3'd5, 1'b1);
    check("R3 bit index 5 ignored", int'(reg_rdata), 6);
    wr_bit(3'd0, 1'b1);
    check("R3 set bit 0", int'(reg_rdata), 7);
    wr_bit(3'd2, 1'b0);
    check("R3 clear bit 2", int'(reg_rdata), 3);

    @(negedge clk); halt = 1'b1;
    wr_byte(8'h0A);
    check("R4 byte write in halt", int'(reg_rdata), 3);
    wr_bit(3'd3, 1'b1);
    check("R4 bit write in halt", int'(reg_rdata), 3);
    @(negedge clk); halt = 1'b0;

    wr_byte(8'h09);
    pulse_stop();
    check("R1 stop clears register", int'(reg_rdata), 0);

    // disabled source and unused gate code
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    cyc(2);
    check("R8 start with source off", int'(busy), 0);
    wr_byte(8'h07);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    cyc(2);
    check("R8 start with open gate", int'(busy), 0);

    // AM in AM mode, 1 tick, slow square wave; FM toggles but is unselected
    am_half = 3; fm_half = 1;
    wr_byte(8'h04);
    run_gate(TB_DIV, 0, "R7 gate 1 tick");
    check("R11 done after close", int'(done), 1);
    cyc(10);
    check("R11 done held", int'(done), 1);

    // FM in FM mode, 4 ticks
    am_half = 1; fm_half = 2;
    wr_byte(8'h09);
    run_gate(4 * TB_DIV, 0, "R7 gate 4 ticks");
    check("R6 am released in FM mode", int'(am_released), 1);

    // cross code: FM input held low, AM input toggling fast
    am_half = 1; fm_half = 0;
    wr_byte(8'h0E);
    run_gate(8 * TB_DIV, 0, "R7 gate 8 ticks");
    check("R9 unselected input ignored", int'(result), 0);
    check("R5 cross code in AM mode", int'(am_count_mode), 1);

    // saturation: toggle every cycle over the longest gate
    am_half = 1; fm_half = 0;
    wr_byte(8'h06);
    run_gate(8 * TB_DIV, 0, "R7 gate 8 ticks sat");
    check("R10 saturated result", int'(result), MAXV);

    // second start while busy is ignored
    am_half = 2;
    wr_byte(8'h04);
    run_gate(TB_DIV, 5, "R8 restart while busy");

    // new start clears done; then abort
    wr_byte(8'h08);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    check("R11 start clears done", int'(done), 0);
    cyc(5);
    pulse_stop();
    check("R12 stop aborts busy", int'(busy), 0);
    check("R12 stop leaves done low", int'(done), 0);
    check("R1 stop clears register mid-run", int'(reg_rdata), 0);

    cyc(5);
    finish_run();
  end

endmodule